// File: doc/BRIEF.md
# Synthesizer Serial Configuration Register Bank

This block is the serial configuration front end of a fractional-N frequency synthesizer. A host shifts 24-bit frames into it over a three-wire serial port (serial clock, active-low select, bidirectional data). Each frame carries a direction flag, a 15-bit register address and one data byte. Writes land in a byte-wide register bank when the select line is released. Reads return the addressed byte on the data line during the last eight bits of the same frame.

The bank holds everything the synthesizer core needs: the 16-bit integer divide value, the 25-bit primary fraction, the 14-bit auxiliary fraction and auxiliary modulus, a 24-bit phase word, the reference divide value, the output divider select and the charge pump and power controls. The divider settings reach the core through a shadow stage. A host can therefore rewrite the fractions and modulus one byte at a time without the core ever seeing a half-updated value. Writing the low byte of the integer word then applies all of them together.

All logic runs in one system clock domain. The serial pins are synchronised and their edges are detected in that domain, so the serial clock must be several times slower than the system clock.

Top module: `cfg_synth_regfile`

## Requirements
- R1: A frame starts when `csb` falls. Bits are sampled on rising `sclk` edges: first the direction flag (1 = read), then 15 address bits, then 8 data bits. A write takes effect on the rising edge of `csb`, and only if exactly 24 rising `sclk` edges were seen in the frame. Frames with fewer or more edges change nothing.
- R2: Bit 0 of register 0x00 selects the bit order for the frames that follow: 0 = most significant bit first, 1 = least significant bit first. The order applies to both the address and the data field, and to read data. The direction flag is always the first bit.
- R3: In a read frame, `sdio_oe` rises on the falling `sclk` edge after the 16th rising edge, and each data bit on `sdio_out` changes on a falling edge. `sdio_oe` is low during write frames and falls when `csb` rises. A read frame never modifies any register.
- R4: Reset values: 0x12=0x40, 0x19=0xE8, 0x1A=0x03, 0x1E=0x48, 0x1F=0x01, 0x20=0x14, 0x24=0x80, 0x25=0x07, 0x27=0xC1, 0x28=0x03. All other mapped bytes reset to 0x00. After reset the active modulus output is 0x03E8 and all other active divider outputs are 0.
- R5: Reserved bits ignore writes and always read as their reset value. The writable masks are: 0x00=0x01, 0x12=0x60, 0x18=0x7F, 0x1A=0x7F, 0x24=0xF0, 0x25=0xBF, 0x27=0xF8, 0x28=0x87. Every other mapped byte is fully writable.
- R6: The mapped addresses are 0x00, 0x10 to 0x12, 0x14 to 0x20, 0x24, 0x25, 0x27 and 0x28. Writes to any other 15-bit address, including addresses with any bit above bit 5 set, are discarded, and reads of them return 0x00.
- R7: `int_word` = {0x11, 0x10}. It changes only when 0x10 is written. A write to 0x11 alone stays pending.
- R8: The pending values are primary fraction = {0x17[0], 0x16, 0x15, 0x14}, auxiliary fraction = {0x18[6:0], 0x17[7:1]} and auxiliary modulus = {0x1A[5:0], 0x19}. They are copied to `frac1`, `frac2` and `mod2` only when 0x10 is written.
- R9: The divider select is 0x24[6:4]. When 0x28[7] is 1, `div_sel` updates only on a write of 0x10. When 0x28[7] is 0, it follows the register directly.
- R10: The direct control outputs are:
  - `cp_current` = 0x1E[7:4], `pd_pol` = 0x1E[3], `synth_pd` = 0x1E[2], `cp_tristate` = 0x1E[1], `counter_hold` = 0x1E[0]
  - `autocal_en` = 0x12[6], `prescaler_sel` = 0x12[5]
  - `r_word` = {0x20[1:0], 0x1F}
  - `phase_word` = {0x1D, 0x1C, 0x1B}, `phase_adj_en` = 0x1A[6]
  - `fb_sel` = 0x24[7]

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock |
| csb | input | 1 | Serial select, active low |
| sdio_in | input | 1 | Serial data from host |
| sdio_out | output | 1 | Serial read data |
| sdio_oe | output | 1 | Drive enable for the serial data pad |
| int_word | output | 16 | Active integer divide value |
| frac1 | output | 25 | Active primary fraction |
| frac2 | output | 14 | Active auxiliary fraction |
| mod2 | output | 14 | Active auxiliary modulus |
| div_sel | output | 3 | Active output divider select |
| fb_sel | output | 1 | Feedback source select |
| phase_word | output | 24 | Phase adjust word |
| phase_adj_en | output | 1 | Phase adjust enable |
| prescaler_sel | output | 1 | Prescaler ratio select |
| autocal_en | output | 1 | Oscillator calibration enable |
| cp_current | output | 4 | Charge pump current code |
| pd_pol | output | 1 | Phase detector polarity |
| synth_pd | output | 1 | Synthesizer power down |
| cp_tristate | output | 1 | Charge pump output tri-state |
| counter_hold | output | 1 | Holds the N and R counters in reset |
| r_word | output | 10 | Reference divide value |

## Verification
The hardest condition to reach is a divider output that deliberately lags its register. This happens when the fractions, the modulus or a double-buffered divider select have been rewritten but the integer low byte has not yet been written. The bench keeps its own model of pending and active values. It compares every core output after every write frame of a full write sweep over the low address page, and it also runs targeted sequences that write 0x11, the fraction bytes and 0x24 before finishing with 0x10. Bit-order switching is reached naturally: the sweep writes 0x00 with all ones, and the following readback and clearing frames then run in least-significant-first order.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    localparam int CFG_ADDR_W = 15;
    localparam int CFG_DATA_W = 8;
    localparam int CFG_PAGE_AW = 6;

    // Byte addresses whose position the core decodes
    localparam int A_ORDER   = 'h00;
    localparam int A_INT_LO  = 'h10;
    localparam int A_INT_HI  = 'h11;
    localparam int A_CAL     = 'h12;
    localparam int A_F1_0    = 'h14;
    localparam int A_F1_1    = 'h15;
    localparam int A_F1_2    = 'h16;
    localparam int A_F1F2    = 'h17;
    localparam int A_F2_HI   = 'h18;
    localparam int A_M2_LO   = 'h19;
    localparam int A_M2_HI   = 'h1A;
    localparam int A_PH_0    = 'h1B;
    localparam int A_PH_1    = 'h1C;
    localparam int A_PH_2    = 'h1D;
    localparam int A_PUMP    = 'h1E;
    localparam int A_REF_LO  = 'h1F;
    localparam int A_REF_HI  = 'h20;
    localparam int A_OUTDIV  = 'h24;
    localparam int A_DBUF    = 'h28;

    function automatic logic cfg_is_mapped(input int a);
        return (a == 'h00) || (a >= 'h10 && a <= 'h12) || (a >= 'h14 && a <= 'h20) ||
               (a == 'h24) || (a == 'h25) || (a == 'h27) || (a == 'h28);
    endfunction

    function automatic logic [7:0] cfg_reset_value(input int a);
        case (a)
            'h12:    return 8'h40;
            'h19:    return 8'hE8;
            'h1A:    return 8'h03;
            'h1E:    return 8'h48;
            'h1F:    return 8'h01;
            'h20:    return 8'h14;
            'h24:    return 8'h80;
            'h25:    return 8'h07;
            'h27:    return 8'hC1;
            'h28:    return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] cfg_write_mask(input int a);
        if (!cfg_is_mapped(a)) return 8'h00;
        case (a)
            'h00:    return 8'h01;
            'h12:    return 8'h60;
            'h18:    return 8'h7F;
            'h1A:    return 8'h7F;
            'h24:    return 8'hF0;
            'h25:    return 8'hBF;
            'h27:    return 8'hF8;
            'h28:    return 8'h87;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              csb,
    input  logic              sdio_in,
    input  logic              order_lsb,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdio_out,
    output logic              sdio_oe
);
    localparam int FRAME_W = 1 + ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] C_DATA = CNT_W'(1 + ADDR_W);
    localparam logic [CNT_W-1:0] C_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] C_OVER = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic [2:0]        sclk_sy;
        logic [2:0]        csb_sy;
        logic [1:0]        sdi_sy;
        logic              busy;
        logic              lsb;
        logic [CNT_W-1:0]  cnt;
        logic              rw;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] osh;
        logic              oe;
        logic              wr_stb;
    } port_t;

    port_t st_q, st_d;

    logic sclk_rise, sclk_fall, csb_rise, csb_fall, bit_in;

    always_comb begin
        sclk_rise = st_q.sclk_sy[1] & ~st_q.sclk_sy[2];
        sclk_fall = ~st_q.sclk_sy[1] & st_q.sclk_sy[2];
        csb_rise  = st_q.csb_sy[1] & ~st_q.csb_sy[2];
        csb_fall  = ~st_q.csb_sy[1] & st_q.csb_sy[2];
        bit_in    = st_q.sdi_sy[1];

        st_d         = st_q;
        st_d.wr_stb  = 1'b0;
        st_d.sclk_sy = {st_q.sclk_sy[1:0], sclk};
        st_d.csb_sy  = {st_q.csb_sy[1:0], csb};
        st_d.sdi_sy  = {st_q.sdi_sy[0], sdio_in};

        if (csb_fall) begin
            st_d.busy = 1'b1;
            st_d.lsb  = order_lsb;
            st_d.cnt  = '0;
            st_d.rw   = 1'b0;
            st_d.addr = '0;
            st_d.data = '0;
            st_d.oe   = 1'b0;
        end else if (csb_rise) begin
            st_d.wr_stb = st_q.busy && (st_q.cnt == C_FULL) && !st_q.rw;
            st_d.busy   = 1'b0;
            st_d.oe     = 1'b0;
        end else if (st_q.busy) begin
            if (sclk_rise && st_q.cnt != C_OVER) begin
                if (st_q.cnt == '0) begin
                    st_d.rw = bit_in;
                end else if (st_q.cnt < C_DATA) begin
                    st_d.addr = st_q.lsb ? {bit_in, st_q.addr[ADDR_W-1:1]}
                                         : {st_q.addr[ADDR_W-2:0], bit_in};
                end else if (st_q.cnt < C_FULL) begin
                    st_d.data = st_q.lsb ? {bit_in, st_q.data[DATA_W-1:1]}
                                         : {st_q.data[DATA_W-2:0], bit_in};
                end
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (sclk_fall && st_q.rw) begin
                if (st_q.cnt == C_DATA) begin
                    st_d.osh = rd_data;
                    st_d.oe  = 1'b1;
                end else if (st_q.cnt > C_DATA && st_q.cnt < C_FULL) begin
                    st_d.osh = st_q.lsb ? {1'b0, st_q.osh[DATA_W-1:1]}
                                        : {st_q.osh[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.csb_sy  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr  = st_q.addr;
    assign wr_addr  = st_q.addr;
    assign wr_data  = st_q.data;
    assign wr_stb   = st_q.wr_stb;
    assign sdio_oe  = st_q.oe;
    assign sdio_out = st_q.oe & (st_q.lsb ? st_q.osh[0] : st_q.osh[DATA_W-1]);

    // R3: the data pad is released once the select line returns high
    a_r3_release_on_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.csb_sy[1]) |=> !sdio_oe);

    // R1: a write strobe only follows a frame of exactly full length
    a_r1_full_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(st_q.cnt) == C_FULL) && !$past(st_q.rw));

    // R3: the pad is never driven while a write frame is in progress
    a_r3_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !st_q.rw) |-> !sdio_oe);

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import synth_cfg_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 8,
    parameter int PAGE_AW = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                 rd_data,
    output logic [(1<<PAGE_AW)-1:0][DATA_W-1:0] regs,
    output logic                              commit
);
    localparam int N_BYTES = 1 << PAGE_AW;

    typedef struct packed {
        logic [N_BYTES-1:0][DATA_W-1:0] mem;
        logic                           commit;
    } bank_t;

    bank_t bk_q, bk_d;

    logic [N_BYTES-1:0][DATA_W-1:0] reset_img;
    logic [N_BYTES-1:0][DATA_W-1:0] mask_img;

    for (genvar gi = 0; gi < N_BYTES; gi++) begin : g_image
        assign reset_img[gi] = DATA_W'(cfg_reset_value(gi));
        assign mask_img[gi]  = DATA_W'(cfg_write_mask(gi));
    end

    logic              wr_in_page, rd_in_page;
    logic [PAGE_AW-1:0] wr_idx, rd_idx;

    always_comb begin
        wr_in_page = (wr_addr[ADDR_W-1:PAGE_AW] == '0);
        rd_in_page = (rd_addr[ADDR_W-1:PAGE_AW] == '0);
        wr_idx     = wr_addr[PAGE_AW-1:0];
        rd_idx     = rd_addr[PAGE_AW-1:0];

        bk_d        = bk_q;
        bk_d.commit = 1'b0;
        if (wr_en && wr_in_page) begin
            bk_d.mem[wr_idx] = (bk_q.mem[wr_idx] & ~mask_img[wr_idx]) |
                               (wr_data & mask_img[wr_idx]);
            bk_d.commit      = (wr_idx == PAGE_AW'(A_INT_LO));
        end
        rd_data = rd_in_page ? bk_q.mem[rd_idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q.mem    <= reset_img;
            bk_q.commit <= 1'b0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign regs   = bk_q.mem;
    assign commit = bk_q.commit;

    // R6: a write outside the page or to an unmapped byte leaves the bank untouched
    a_r6_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (!wr_in_page || mask_img[wr_idx] == '0)) |=> $stable(bk_q.mem));

    // R5: reserved low bits of the lock detect byte keep their reset pattern
    a_r5_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bk_q.mem[A_DBUF - 1][2:0] == 3'b001);

    // R7: the commit pulse follows a write of the integer low byte
    a_r7_commit_source: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(wr_en && wr_in_page && wr_idx == PAGE_AW'(A_INT_LO)));

endmodule

// File: rtl/cfg_shadow_stage.sv
module cfg_shadow_stage #(
    parameter int INT_W  = 16,
    parameter int F1_W   = 25,
    parameter int F2_W   = 14,
    parameter int M2_W   = 14,
    parameter int DIV_W  = 3,
    parameter logic [M2_W-1:0] M2_RESET = 14'h03E8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             div_dbuf,
    input  logic [INT_W-1:0] int_pend,
    input  logic [F1_W-1:0]  f1_pend,
    input  logic [F2_W-1:0]  f2_pend,
    input  logic [M2_W-1:0]  m2_pend,
    input  logic [DIV_W-1:0] div_pend,
    output logic [INT_W-1:0] int_act,
    output logic [F1_W-1:0]  f1_act,
    output logic [F2_W-1:0]  f2_act,
    output logic [M2_W-1:0]  m2_act,
    output logic [DIV_W-1:0] div_act
);
    typedef struct packed {
        logic [INT_W-1:0] int_w;
        logic [F1_W-1:0]  f1;
        logic [F2_W-1:0]  f2;
        logic [M2_W-1:0]  m2;
        logic [DIV_W-1:0] div;
    } shadow_t;

    shadow_t sh_q, sh_d;

    always_comb begin
        sh_d = sh_q;
        if (commit) begin
            sh_d.int_w = int_pend;
            sh_d.f1    = f1_pend;
            sh_d.f2    = f2_pend;
            sh_d.m2    = m2_pend;
        end
        if (!div_dbuf || commit) begin
            sh_d.div = div_pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            sh_q.m2 <= M2_RESET;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign int_act = sh_q.int_w;
    assign f1_act  = sh_q.f1;
    assign f2_act  = sh_q.f2;
    assign m2_act  = sh_q.m2;
    assign div_act = sh_q.div;

    // R8: active fractions and modulus hold between commits
    a_r8_frac_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({f1_act, f2_act, m2_act}));

    // R7: active integer word holds between commits
    a_r7_int_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(int_act));

    // R9: with double buffering on, the divider select waits for a commit
    a_r9_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (div_dbuf && !commit) |=> $stable(div_act));

    // R8: a commit lands the pending values
    a_r8_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (f1_act == $past(f1_pend)) && (m2_act == $past(m2_pend)));

endmodule

// File: rtl/cfg_synth_regfile.sv
module cfg_synth_regfile
    import synth_cfg_pkg::*;
#(
    parameter int ADDR_W  = CFG_ADDR_W,
    parameter int DATA_W  = CFG_DATA_W,
    parameter int PAGE_AW = CFG_PAGE_AW
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        csb,
    input  logic        sdio_in,
    output logic        sdio_out,
    output logic        sdio_oe,
    output logic [15:0] int_word,
    output logic [24:0] frac1,
    output logic [13:0] frac2,
    output logic [13:0] mod2,
    output logic [2:0]  div_sel,
    output logic        fb_sel,
    output logic [23:0] phase_word,
    output logic        phase_adj_en,
    output logic        prescaler_sel,
    output logic        autocal_en,
    output logic [3:0]  cp_current,
    output logic        pd_pol,
    output logic        synth_pd,
    output logic        cp_tristate,
    output logic        counter_hold,
    output logic [9:0]  r_word
);
    localparam int N_BYTES = 1 << PAGE_AW;

    logic [N_BYTES-1:0][DATA_W-1:0] regs;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_stb, commit;
    logic              unused_regs;

    cfg_serial_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .csb       (csb),
        .sdio_in   (sdio_in),
        .order_lsb (regs[A_ORDER][0]),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sdio_out  (sdio_out),
        .sdio_oe   (sdio_oe)
    );

    cfg_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_AW(PAGE_AW)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .regs    (regs),
        .commit  (commit)
    );

    cfg_shadow_stage i_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .div_dbuf (regs[A_DBUF][7]),
        .int_pend ({regs[A_INT_HI], regs[A_INT_LO]}),
        .f1_pend  ({regs[A_F1F2][0], regs[A_F1_2], regs[A_F1_1], regs[A_F1_0]}),
        .f2_pend  ({regs[A_F2_HI][6:0], regs[A_F1F2][7:1]}),
        .m2_pend  ({regs[A_M2_HI][5:0], regs[A_M2_LO]}),
        .div_pend (regs[A_OUTDIV][6:4]),
        .int_act  (int_word),
        .f1_act   (frac1),
        .f2_act   (frac2),
        .m2_act   (mod2),
        .div_act  (div_sel)
    );

    assign fb_sel        = regs[A_OUTDIV][7];
    assign phase_word    = {regs[A_PH_2], regs[A_PH_1], regs[A_PH_0]};
    assign phase_adj_en  = regs[A_M2_HI][6];
    assign prescaler_sel = regs[A_CAL][5];
    assign autocal_en    = regs[A_CAL][6];
    assign cp_current    = regs[A_PUMP][7:4];
    assign pd_pol        = regs[A_PUMP][3];
    assign synth_pd      = regs[A_PUMP][2];
    assign cp_tristate   = regs[A_PUMP][1];
    assign counter_hold  = regs[A_PUMP][0];
    assign r_word        = {regs[A_REF_HI][1:0], regs[A_REF_LO]};
    assign unused_regs   = ^regs;

    // R10: counter hold changes only after a serial write
    a_r10_hold_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb) |-> $stable(counter_hold));

endmodule

// File: tb/test_cfg_synth_regfile.sv
module test_cfg_synth_regfile;

    localparam int HALF = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, sclk, csb, sdio_in;
    logic sdio_out, sdio_oe, fb_sel, phase_adj_en, prescaler_sel, autocal_en;
    logic pd_pol, synth_pd, cp_tristate, counter_hold;
    logic [15:0] int_word;
    logic [24:0] frac1;
    logic [13:0] frac2, mod2;
    logic [2:0]  div_sel;
    logic [23:0] phase_word;
    logic [3:0]  cp_current;
    logic [9:0]  r_word;

    cfg_synth_regfile i_cfg_synth_regfile (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .csb(csb), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .int_word(int_word), .frac1(frac1),
        .frac2(frac2), .mod2(mod2), .div_sel(div_sel), .fb_sel(fb_sel),
        .phase_word(phase_word), .phase_adj_en(phase_adj_en),
        .prescaler_sel(prescaler_sel), .autocal_en(autocal_en),
        .cp_current(cp_current), .pd_pol(pd_pol), .synth_pd(synth_pd),
        .cp_tristate(cp_tristate), .counter_hold(counter_hold), .r_word(r_word)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic       lsb_mode;
    logic [7:0] mdl [64];
    logic [15:0] e_int;
    logic [24:0] e_f1;
    logic [13:0] e_f2, e_m2;
    logic [2:0]  e_div;

    function automatic bit is_mapped(int a);
        return (a == 0) || (a >= 16 && a <= 18) || (a >= 20 && a <= 32) ||
               (a == 36) || (a == 37) || (a == 39) || (a == 40);
    endfunction

    function automatic logic [7:0] rval(int a);
        case (a)
            18: return 8'h40;  25: return 8'hE8;  26: return 8'h03;
            30: return 8'h48;  31: return 8'h01;  32: return 8'h14;
            36: return 8'h80;  37: return 8'h07;  39: return 8'hC1;
            40: return 8'h03;  default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] wmask(int a);
        if (!is_mapped(a)) return 8'h00;
        case (a)
            0: return 8'h01;   18: return 8'h60;  24: return 8'h7F;
            26: return 8'h7F;  36: return 8'hF0;  37: return 8'hBF;
            39: return 8'hF8;  40: return 8'h87;  default: return 8'hFF;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic frame(input bit rw, input logic [14:0] a, input logic [7:0] d,
                         input int nbits, output logic [7:0] rd, output bit oe_ok);
        rd = '0;
        oe_ok = 1'b1;
        repeat (2) @(negedge clk);
        csb = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            logic b;
            if (i == 0)       b = rw;
            else if (i < 16)  b = lsb_mode ? a[i-1] : a[15-i];
            else if (i < 24)  b = lsb_mode ? d[i-16] : d[23-i];
            else              b = 1'b0;
            sdio_in = b;
            repeat (HALF) @(negedge clk);
            if (rw && i >= 16 && i < 24) begin
                if (!sdio_oe) oe_ok = 1'b0;
                if (lsb_mode) rd[i-16] = sdio_out;
                else          rd[23-i] = sdio_out;
            end
            if (!rw && sdio_oe) oe_ok = 1'b0;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        csb = 1'b1;
        repeat (8) @(negedge clk);
        if (sdio_oe) oe_ok = 1'b0;
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        logic [7:0] rd;
        bit ok;
        frame(1'b0, a, d, 24, rd, ok);
        check("R3", "write frame pad idle", {31'd0, ok}, 32'd1);
        if (a < 64) begin
            mdl[a] = (mdl[a] & ~wmask(a)) | (d & wmask(a));
            if (a == 0) lsb_mode = mdl[0][0];
            if (a == 16) begin
                e_int = {mdl[17], mdl[16]};
                e_f1  = {mdl[23][0], mdl[22], mdl[21], mdl[20]};
                e_f2  = {mdl[24][6:0], mdl[23][7:1]};
                e_m2  = {mdl[26][5:0], mdl[25]};
                if (mdl[40][7]) e_div = mdl[36][6:4];
            end
            if (!mdl[40][7]) e_div = mdl[36][6:4];
        end
    endtask

    task automatic rd_chk(input logic [14:0] a, input logic [7:0] junk, input string req);
        logic [7:0] rd;
        bit ok;
        frame(1'b1, a, junk, 24, rd, ok);
        check(req, $sformatf("read 0x%h", a), {24'd0, rd},
              {24'd0, (a < 64) ? mdl[a] : 8'h00});
        check("R3", "read drive window", {31'd0, ok}, 32'd1);
    endtask

    task automatic core_chk();
        check("R7", "int_word", {16'd0, int_word}, {16'd0, e_int});
        check("R8", "fractions", {frac1[6:0], frac2, mod2[10:0]} ^ {7'd0, frac1[24:7]},
              {e_f1[6:0], e_f2, e_m2[10:0]} ^ {7'd0, e_f1[24:7]});
        check("R8", "mod2", {18'd0, mod2}, {18'd0, e_m2});
        check("R9", "div_sel", {29'd0, div_sel}, {29'd0, e_div});
        check("R10", "controls",
              {fb_sel, phase_adj_en, prescaler_sel, autocal_en, cp_current,
               pd_pol, synth_pd, cp_tristate, counter_hold, r_word, 10'd0},
              {mdl[36][7], mdl[26][6], mdl[18][5], mdl[18][6], mdl[30][7:4],
               mdl[30][3], mdl[30][2], mdl[30][1], mdl[30][0], mdl[32][1:0], mdl[31], 10'd0});
        check("R10", "phase_word", {8'd0, phase_word}, {8'd0, mdl[29], mdl[28], mdl[27]});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        bit ok;
        rst_n = 1'b0; sclk = 1'b0; csb = 1'b1; sdio_in = 1'b0; lsb_mode = 1'b0;
        for (int a = 0; a < 64; a++) mdl[a] = rval(a);
        e_int = '0; e_f1 = '0; e_f2 = '0; e_m2 = 14'h03E8; e_div = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R4: reset state at the ports
        check("R4", "pad idle after reset", {31'd0, sdio_oe}, 32'd0);
        check("R4", "mod2 reset", {18'd0, mod2}, 32'h03E8);
        check("R4", "cp_current reset", {28'd0, cp_current}, 32'd4);
        check("R4", "r_word reset", {22'd0, r_word}, 32'd1);
        core_chk();

        // R4 / R6: reset image of the whole page
        for (int a = 0; a < 64; a++) rd_chk(15'(a), 8'h00, is_mapped(a) ? "R4" : "R6");

        // R5 / R6 / R2: write sweep with all ones and all zeros
        for (int a = 0; a < 64; a++) begin
            wr(15'(a), 8'hFF);
            rd_chk(15'(a), 8'h00, is_mapped(a) ? "R5" : "R6");
            core_chk();
            wr(15'(a), 8'h00);
            rd_chk(15'(a), 8'h00, is_mapped(a) ? "R5" : "R6");
            core_chk();
        end

        // R7 / R8: pending bytes stay invisible until the low integer byte
        wr(15'h14, 8'h55); wr(15'h16, 8'hC3); wr(15'h17, 8'h03);
        wr(15'h18, 8'h2A); wr(15'h19, 8'h12); wr(15'h1A, 8'h05);
        wr(15'h11, 8'hAB);
        core_chk();
        check("R7", "int_word before commit", {16'd0, int_word}, 32'd0);
        wr(15'h10, 8'h34);
        check("R7", "int_word after commit", {16'd0, int_word}, 32'h0000AB34);
        check("R8", "frac1 after commit", {7'd0, frac1}, 32'h01C30055);
        check("R8", "frac2 after commit", {18'd0, frac2}, {18'd0, 7'h2A, 7'h01});
        check("R8", "mod2 after commit", {18'd0, mod2}, 32'h0512);
        core_chk();

        // R9: double-buffered divider select
        wr(15'h28, 8'h83);
        wr(15'h24, 8'h30);
        check("R9", "div held", {29'd0, div_sel}, 32'd0);
        wr(15'h10, 8'h35);
        check("R9", "div on commit", {29'd0, div_sel}, 32'd3);
        wr(15'h28, 8'h03);
        wr(15'h24, 8'hD0);
        check("R9", "div immediate", {29'd0, div_sel}, 32'd5);
        core_chk();

        // R1: short and long frames do not write
        frame(1'b0, 15'h1B, 8'h77, 16, rd, ok);
        rd_chk(15'h1B, 8'h00, "R1");
        frame(1'b0, 15'h1B, 8'h77, 25, rd, ok);
        rd_chk(15'h1B, 8'h00, "R1");
        wr(15'h1B, 8'h77);
        rd_chk(15'h1B, 8'h00, "R1");

        // R6: address bits above the page are decoded
        wr(15'h4014, 8'h99);
        rd_chk(15'h4014, 8'h00, "R6");
        rd_chk(15'h0014, 8'h00, "R6");

        // R3: a read frame with nonzero data bits leaves the register alone
        rd_chk(15'h1B, 8'hFF, "R3");
        rd_chk(15'h1B, 8'h00, "R3");

        // R2: explicit least-significant-first traffic
        wr(15'h00, 8'h01);
        wr(15'h1C, 8'h3C);
        wr(15'h1F, 8'h81);
        rd_chk(15'h1C, 8'h00, "R2");
        rd_chk(15'h1F, 8'h00, "R2");
        check("R2", "phase via lsb frame", {8'd0, phase_word}, {8'd0, mdl[29], 8'h3C, 8'h77});
        wr(15'h00, 8'h00);
        rd_chk(15'h1C, 8'h00, "R2");
        core_chk();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule